// File: doc/BRIEF.md
# Self-Recovering One-Hot Controller

A small control state machine whose state is held as an explicit one-hot vector, with one flip-flop for each state. The states are a post-reset settling state, idle, busy and error. Every cycle a guard counts the set bits of the vector. If none is set, or more than one, the illegal flag rises in that same cycle. On the next clock edge the register is forced back onto the settling path, whatever the other inputs are doing. Recovery is built into the register update itself and does not depend on a default branch.

After a synchronous reset the machine sits in the post-reset state, and the only way out of it is to idle. No working state can be entered until that state has been left. A start request moves idle to busy. From busy, a done input returns to idle and an error event moves to error. Error returns to idle after a single cycle.

A test-only load port writes an arbitrary vector into the state register. It is used to plant corrupted encodings and prove that the machine recovers from them.

Top module: `ohsm_top`

## Requirements
- R1: While `rst` is high at a clock edge, the state register loads 4'b0001, which is the post-reset bit alone. The bit positions are bit0 post-reset, bit1 idle, bit2 busy and bit3 error, and `rst` overrides every other input.
- R2: `illegal` is high in the same cycle exactly when the number of set bits in `state_vec` differs from one, and is low otherwise.
- R3: When `illegal` is high and neither `rst` nor `inj_en` is asserted, the next state is post-reset (4'b0001).
- R4: From post-reset the next state is always idle (4'b0010). `start_req`, `done_in` and `err_evt` have no effect on this step.
- R5: In idle, `start_req` high moves the machine to busy (4'b0100). Otherwise it stays in idle, and `done_in` and `err_evt` are ignored.
- R6: In busy, `err_evt` high moves the machine to error (4'b1000), even when `done_in` is also high. `done_in` high alone returns it to idle. With neither input high it stays in busy.
- R7: From error the next state is idle after one cycle, whatever the inputs are.
- R8: When `inj_en` is high and `rst` is low, the state register loads `inj_vec` in place of the computed next state.
- R9: After any corrupted vector is loaded, including all zeros and two set bits, `state_vec` reaches idle within two clock edges without further injection. No illegal encoding is held for more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to begin work from idle |
| done_in | input | 1 | Work finished, return from busy to idle |
| err_evt | input | 1 | Error event while busy |
| inj_en | input | 1 | Test-only: load `inj_vec` into the state register |
| inj_vec | input | 4 | Test-only: vector to load, may be illegal |
| state_vec | output | 4 | One-hot state vector |
| illegal | output | 1 | High while `state_vec` does not have exactly one bit set |

## Verification
The transition assertions assume that `inj_en` is low in the cycle they observe, because an injection legitimately overrides any computed successor. Their preconditions exclude that case. The stimulus keeps the load port quiet except in single-cycle pulses. Every corrupted vector is followed by at least two cycles with the port idle, so the recovery path runs to completion and can be observed. Control inputs change only on the falling edge, so each rising edge sees one stable combination.

// File: rtl/ohsm_pkg.sv
package ohsm_pkg;

    localparam int NSTATE = 4;

    typedef enum int {
        IX_POST = 0,
        IX_IDLE = 1,
        IX_BUSY = 2,
        IX_ERR  = 3
    } st_idx_e;

    typedef logic [NSTATE-1:0] st_vec_t;

    typedef struct packed {
        logic start;
        logic done;
        logic err;
    } ctl_in_t;

    function automatic st_vec_t hot(input st_idx_e ix);
        st_vec_t v;
        v = '0;
        v[ix] = 1'b1;
        return v;
    endfunction

    function automatic int unsigned bit_total(input st_vec_t v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < NSTATE; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/ohsm_guard.sv
module ohsm_guard
    import ohsm_pkg::*;
(
    input  st_vec_t vec,
    output logic    bad
);
    localparam int unsigned WANT = 1;

    always_comb begin
        bad = (bit_total(vec) != WANT);
    end
endmodule

// File: rtl/ohsm_next.sv
module ohsm_next
    import ohsm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  st_vec_t cur,
    input  logic    bad,
    input  ctl_in_t ctl,
    input  logic    inj_en,
    output st_vec_t nxt
);
    always_comb begin
        nxt = hot(IX_POST);
        if (!bad) begin
            if (cur[IX_POST]) begin
                nxt = hot(IX_IDLE);
            end else if (cur[IX_IDLE]) begin
                nxt = ctl.start ? hot(IX_BUSY) : hot(IX_IDLE);
            end else if (cur[IX_BUSY]) begin
                if (ctl.err)       nxt = hot(IX_ERR);
                else if (ctl.done) nxt = hot(IX_IDLE);
                else               nxt = hot(IX_BUSY);
            end else begin
                nxt = hot(IX_IDLE);
            end
        end
    end

    // R4: post-reset leads only to idle
    a_r4_post_to_idle: assert property (@(posedge clk) disable iff (rst)
        (cur == hot(IX_POST) && !inj_en) |=> (cur == hot(IX_IDLE)));

    // R5: start from idle reaches busy
    a_r5_idle_start: assert property (@(posedge clk) disable iff (rst)
        (cur == hot(IX_IDLE) && ctl.start && !inj_en) |=> (cur == hot(IX_BUSY)));

    // R6: error wins over done in busy
    a_r6_busy_err: assert property (@(posedge clk) disable iff (rst)
        (cur == hot(IX_BUSY) && ctl.err && !inj_en) |=> (cur == hot(IX_ERR)));

    // R7: error lasts one cycle
    a_r7_err_to_idle: assert property (@(posedge clk) disable iff (rst)
        (cur == hot(IX_ERR) && !inj_en) |=> (cur == hot(IX_IDLE)));
endmodule

// File: rtl/ohsm_top.sv
module ohsm_top
    import ohsm_pkg::*;
#(
    parameter int W = ohsm_pkg::NSTATE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_req,
    input  logic         done_in,
    input  logic         err_evt,
    input  logic         inj_en,
    input  logic [W-1:0] inj_vec,
    output logic [W-1:0] state_vec,
    output logic         illegal
);
    st_vec_t state_q;
    st_vec_t next_d;
    logic    bad;
    ctl_in_t ctl;

    assign ctl = '{start: start_req, done: done_in, err: err_evt};

    ohsm_guard u_guard (
        .vec (state_q),
        .bad (bad)
    );

    ohsm_next u_next (
        .clk    (clk),
        .rst    (rst),
        .cur    (state_q),
        .bad    (bad),
        .ctl    (ctl),
        .inj_en (inj_en),
        .nxt    (next_d)
    );

    always_ff @(posedge clk) begin
        if (rst)         state_q <= hot(IX_POST);
        else if (inj_en) state_q <= st_vec_t'(inj_vec);
        else             state_q <= next_d;
    end

    assign state_vec = W'(state_q);
    assign illegal   = bad;

    // R1: reset lands on post-reset alone
    a_r1_reset_post: assert property (@(posedge clk)
        rst |=> (state_vec == W'(hot(IX_POST))));

    // R3: a flagged vector is replaced by post-reset
    a_r3_recover: assert property (@(posedge clk) disable iff (rst)
        (illegal && !inj_en) |=> (state_vec == W'(hot(IX_POST))));

    // R9: without injection the vector stays legal
    a_r9_no_stable_bad: assert property (@(posedge clk) disable iff (rst)
        !inj_en |=> !illegal);

    // R8: an injection is loaded as given
    a_r8_inject: assert property (@(posedge clk) disable iff (rst)
        inj_en |=> (state_vec == $past(inj_vec)));
endmodule

// File: tb/ohsm_top_bench.sv
module ohsm_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0, done_in = 1'b0, err_evt = 1'b0;
    logic       inj_en = 1'b0;
    logic [3:0] inj_vec = 4'b0000;
    logic [3:0] state_vec;
    logic       illegal;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [3:0] model = 4'b0001;

    localparam logic [3:0] P = 4'b0001, I = 4'b0010, B = 4'b0100, E = 4'b1000;

    ohsm_top u_ohsm_top (
        .clk(clk), .rst(rst), .start_req(start_req), .done_in(done_in),
        .err_evt(err_evt), .inj_en(inj_en), .inj_vec(inj_vec),
        .state_vec(state_vec), .illegal(illegal)
    );

    always #2 clk = ~clk;

    function automatic int ones(input logic [3:0] v);
        int n = 0;
        for (int i = 0; i < 4; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic [3:0] ref_next(input logic [3:0] m, input logic r,
        input logic s, input logic d, input logic e, input logic ie, input logic [3:0] iv);
        if (r) return P;
        if (ie) return iv;
        if (ones(m) != 1) return P;
        if (m == P) return I;
        if (m == I) return s ? B : I;
        if (m == B) return e ? E : (d ? I : B);
        return I;
    endfunction

    task automatic check(input string tag);
        checks++;
        if (state_vec !== model) begin
            fails++;
            $display("FAIL %s state_vec actual=%b expected=%b", tag, state_vec, model);
        end
        checks++;
        if (illegal !== (ones(model) != 1)) begin
            fails++;
            $display("FAIL R2 (%s) illegal actual=%b expected=%b", tag, illegal, ones(model) != 1);
        end
    endtask

    task automatic step(input logic r, input logic s, input logic d, input logic e,
        input logic ie, input logic [3:0] iv, input string tag);
        rst = r; start_req = s; done_in = d; err_evt = e; inj_en = ie; inj_vec = iv;
        @(posedge clk);
        model = ref_next(model, r, s, d, e, ie, iv);
        @(negedge clk);
        check(tag);
    endtask

    task automatic corrupt(input logic [3:0] v);
        int n = 0;
        step(0, 1, 1, 1, 1, v, "R8");
        while (state_vec !== I && n < 4) begin
            step(0, 1, 1, 1, 0, 4'b0, "R3");
            n++;
        end
        checks++;
        if (n > 2 || state_vec !== I) begin
            fails++;
            $display("FAIL R9 edges to idle actual=%0d expected<=2 (vec %b)", n, v);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(1, 1, 1, 1, 1, 4'b1111, "R1");
        step(1, 0, 0, 0, 0, 4'b0, "R1");
        step(0, 1, 1, 1, 0, 4'b0, "R4");
        step(0, 0, 1, 1, 0, 4'b0, "R5");
        step(0, 0, 0, 0, 0, 4'b0, "R5");
        step(0, 1, 0, 0, 0, 4'b0, "R5");
        step(0, 0, 0, 0, 0, 4'b0, "R6");
        step(0, 0, 1, 0, 0, 4'b0, "R6");
        step(0, 1, 0, 0, 0, 4'b0, "R5");
        step(0, 0, 1, 1, 0, 4'b0, "R6");
        step(0, 1, 1, 1, 0, 4'b0, "R7");
        step(0, 0, 0, 0, 0, 4'b0, "R7");
        corrupt(4'b0000);
        corrupt(4'b1010);
        corrupt(4'b0110);
        corrupt(4'b1111);
        step(0, 0, 0, 0, 1, B, "R8");
        step(0, 0, 0, 1, 0, 4'b0, "R6");
        step(0, 0, 0, 0, 1, 4'b0011, "R8");
        step(1, 0, 0, 0, 0, 4'b0, "R1");
        step(0, 0, 0, 0, 0, 4'b0, "R4");
        step(0, 0, 0, 0, 0, 4'b0, "R5");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule